// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Mask

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it can accept one operation code, a register operand, a memory operand and the incoming carry. One clock later it presents the computed byte and the four status flags: negative, overflow, zero and carry. Alongside them it presents an update mask that names the flags this operation is allowed to change, and a write strobe that says whether the result byte should be stored.

The surrounding core keeps its own flag register. It merges only the masked flag bits and writes the result back only when the strobe is set. Compare and bit test produce flags without a stored result. Unary operations (shifts, rotates, increment, decrement) act on the register operand; a memory variant is made by routing the memory byte into that operand. Decimal arithmetic, register storage and instruction fetch lie outside the block.

Top module: `alu8_unit`

## Requirements
- R1: Outputs are registered: `out_valid` equals `in_valid` from one cycle earlier, and the other outputs reflect the operation accepted in that cycle. A synchronous active-high reset clears every output to zero.
- R2: Code 0x0 (add) gives result = (R + M + carry_in) mod 256. C is the carry out of bit 7, V is set when R and M share a sign that the result lacks. Mask is 4'b1111 (bit 3 N, bit 2 V, bit 1 Z, bit 0 C) and the write strobe is 1.
- R3: Code 0x1 (subtract) gives result = (R - M - (1 - carry_in)) mod 256. C is 1 exactly when no borrow occurs, and V is set when R and M differ in sign and the result's sign differs from R. Mask is 4'b1111 and the write strobe is 1.
- R4: Codes 0x2 (AND), 0x3 (OR) and 0x4 (XOR) give the bitwise result with mask 4'b1010 and the write strobe at 1. The V and C outputs are 0 whatever carry_in is.
- R5: Codes 0x5 (shift left), 0x6 (logical shift right), 0x7 (rotate left) and 0x8 (rotate right) act on R with mask 4'b1011. C takes old bit 7 for left moves and old bit 0 for right moves. The vacated bit is 0 for shifts and carry_in for rotates.
- R6: Code 0x9 (compare) sets flags from R - M with C = 1 when R >= M unsigned. The mask is 4'b1011, the write strobe is 0, and the result port shows the difference mod 256.
- R7: Code 0xA (increment) and code 0xB (decrement) give R + 1 or R - 1 mod 256, with mask 4'b1010 and the write strobe at 1.
- R8: Code 0xC (bit test) gives Z = ((R & M) == 0), N = M bit 7 and V = M bit 6. The mask is 4'b1110, the write strobe is 0, and the result port shows R & M.
- R9: For every code except bit test, N equals result bit 7 and Z is set exactly when the result is zero. Any flag outside the mask is driven as 0.
- R10: While `in_valid` is low, the result, flag, mask and strobe outputs keep their values and `out_valid` is 0.
- R11: Reserved codes 0xD to 0xF give a zero result, zero flags, mask 4'b0000 and write strobe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| opnd_r | input | W (8) | Register operand |
| opnd_m | input | W (8) | Memory operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs belong to a new operation |
| result | output | W (8) | Computed byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| upd_mask | output | 4 | Flags to update {N,V,Z,C} |
| wr_result | output | 1 | Result should be stored |

## Verification
The block holds no state beyond its output register, so any fault shows at the ports in the cycle right after the operation is accepted. A wrong carry chain shows as a wrong result byte and a wrong C flag. A wrong operand inversion on subtract or compare also flips the borrow sense. A mis-decoded code shows as a wrong mask or strobe, such as compare writing back or a logic operation touching V. A bad hold enable shows as outputs that change in idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_AND   = 4'h2,
    OP_OR    = 4'h3,
    OP_XOR   = 4'h4,
    OP_SHL   = 4'h5,
    OP_SHR   = 4'h6,
    OP_ROL   = 4'h7,
    OP_ROR   = 4'h8,
    OP_CMP   = 4'h9,
    OP_INC   = 4'hA,
    OP_DEC   = 4'hB,
    OP_BIT   = 4'hC,
    OP_RSV_D = 4'hD,
    OP_RSV_E = 4'hE,
    OP_RSV_F = 4'hF
  } alu_op_e;

  // mask bit order {N,V,Z,C}
  localparam logic [3:0] MASK_ARITH = 4'b1111;
  localparam logic [3:0] MASK_LOGIC = 4'b1010;
  localparam logic [3:0] MASK_SHIFT = 4'b1011;
  localparam logic [3:0] MASK_TEST  = 4'b1110;
  localparam logic [3:0] MASK_NONE  = 4'b0000;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int SW = W + 1;

  logic [W-1:0]  b_eff;
  logic [SW-1:0] wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
  assign ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_y,
  output logic [W-1:0] or_y,
  output logic [W-1:0] xor_y
);
  assign and_y = a & b;
  assign or_y  = a | b;
  assign xor_y = a ^ b;
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         right,
  input  logic         rotate,
  output logic [W-1:0] y,
  output logic         cout
);
  logic fill;
  assign fill = rotate & cin;
  assign cout = right ? a[0] : a[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign y[i] = right ? a[i+1] : fill;
    end else if (i == W - 1) begin : g_msb
      assign y[i] = right ? fill : a[i-1];
    end else begin : g_mid
      assign y[i] = right ? a[i+1] : a[i-1];
    end
  end
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         down,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = W'(1);
  assign y = down ? (a - ONE) : (a + ONE);
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_r,
  input  logic [W-1:0] opnd_m,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c,
  output logic [3:0]   upd_mask,
  output logic         wr_result
);
  localparam int MSB = W - 1;
  localparam int VB  = W - 2;

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // arithmetic core shared by add, subtract and compare
  logic         as_sub, as_cin, as_cout, as_ovf;
  logic [W-1:0] as_sum;
  assign as_sub = (op == OP_SUB) || (op == OP_CMP);
  assign as_cin = (op == OP_CMP) ? 1'b1 : carry_in;

  alu8_addsub #(.W(W)) u_addsub (
    .a(opnd_r), .b(opnd_m), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  logic [W-1:0] and_y, or_y, xor_y;
  alu8_bitwise #(.W(W)) u_bitwise (
    .a(opnd_r), .b(opnd_m), .and_y(and_y), .or_y(or_y), .xor_y(xor_y)
  );

  logic         sh_right, sh_rot, sh_cout;
  logic [W-1:0] sh_y;
  assign sh_right = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  alu8_shifter #(.W(W)) u_shifter (
    .a(opnd_r), .cin(carry_in), .right(sh_right), .rotate(sh_rot),
    .y(sh_y), .cout(sh_cout)
  );

  logic [W-1:0] st_y;
  alu8_step #(.W(W)) u_step (
    .a(opnd_r), .down(op == OP_DEC), .y(st_y)
  );

  // selection and flag formation
  logic [W-1:0] res_d;
  flags_t       raw_d, flg_d;
  logic [3:0]   mask_d;
  logic         wr_d;

  always_comb begin
    res_d   = '0;
    raw_d   = '0;
    mask_d  = MASK_NONE;
    wr_d    = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d   = as_sum;
        raw_d.c = as_cout;
        raw_d.v = as_ovf;
        mask_d  = MASK_ARITH;
        wr_d    = 1'b1;
      end
      OP_CMP: begin
        res_d   = as_sum;
        raw_d.c = as_cout;
        mask_d  = MASK_SHIFT;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d  = (op == OP_AND) ? and_y : ((op == OP_OR) ? or_y : xor_y);
        mask_d = MASK_LOGIC;
        wr_d   = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_d   = sh_y;
        raw_d.c = sh_cout;
        mask_d  = MASK_SHIFT;
        wr_d    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_d  = st_y;
        mask_d = MASK_LOGIC;
        wr_d   = 1'b1;
      end
      OP_BIT: begin
        res_d  = and_y;
        mask_d = MASK_TEST;
      end
      default: ;
    endcase
    raw_d.z = (res_d == '0);
    raw_d.n = (op == OP_BIT) ? opnd_m[MSB] : res_d[MSB];
    if (op == OP_BIT) raw_d.v = opnd_m[VB];
    flg_d = raw_d & flags_t'(mask_d);
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      upd_mask  <= '0;
      wr_result <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_d;
        flag_n    <= flg_d.n;
        flag_v    <= flg_d.v;
        flag_z    <= flg_d.z;
        flag_c    <= flg_d.c;
        upd_mask  <= mask_d;
        wr_result <= wr_d;
      end
    end
  end

  // assertions
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(upd_mask) && $stable(wr_result));
  p_logic_vc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op_sel == 4'h2 || op_sel == 4'h3 || op_sel == 4'h4)
    |=> !flag_v && !flag_c && upd_mask == 4'b1010);
  p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 4'h9 |=> !wr_result && upd_mask == 4'b1011);
  p_bit_sign_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 4'hC |=> flag_n == $past(opnd_m[MSB]) && !wr_result);
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && upd_mask[1] && upd_mask != 4'b1110 |-> flag_z == (result == '0));
  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel >= 4'hD |=> upd_mask == 4'b0000 && !wr_result);
endmodule

// File: tb/tb_alu8_unit.sv
module tb_alu8_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] op_sel;
  logic [7:0] opnd_r, opnd_m;
  logic       carry_in;
  logic       out_valid;
  logic [7:0] result;
  logic       flag_n, flag_v, flag_z, flag_c;
  logic [3:0] upd_mask;
  logic       wr_result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu8_unit #(.W(8)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_r(opnd_r), .opnd_m(opnd_m), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c), .upd_mask(upd_mask), .wr_result(wr_result)
  );

  // vector: {op, r, m, cin, res, flags NVZC, mask, wr}
  localparam int NV = 19;
  localparam logic [37:0] TBL [NV] = '{
    {4'h0, 8'h50, 8'h50, 1'b0, 8'hA0, 4'b1100, 4'b1111, 1'b1},
    {4'h0, 8'hFF, 8'h01, 1'b0, 8'h00, 4'b0011, 4'b1111, 1'b1},
    {4'h0, 8'h10, 8'h20, 1'b1, 8'h31, 4'b0000, 4'b1111, 1'b1},
    {4'h1, 8'h50, 8'hB0, 1'b1, 8'hA0, 4'b1100, 4'b1111, 1'b1},
    {4'h1, 8'h05, 8'h05, 1'b0, 8'hFF, 4'b1000, 4'b1111, 1'b1},
    {4'h1, 8'h05, 8'h03, 1'b1, 8'h02, 4'b0001, 4'b1111, 1'b1},
    {4'h2, 8'hF0, 8'h0F, 1'b1, 8'h00, 4'b0010, 4'b1010, 1'b1},
    {4'h3, 8'h80, 8'h01, 1'b1, 8'h81, 4'b1000, 4'b1010, 1'b1},
    {4'h4, 8'hAA, 8'hFF, 1'b0, 8'h55, 4'b0000, 4'b1010, 1'b1},
    {4'h5, 8'h81, 8'h00, 1'b1, 8'h02, 4'b0001, 4'b1011, 1'b1},
    {4'h6, 8'h01, 8'h00, 1'b1, 8'h00, 4'b0011, 4'b1011, 1'b1},
    {4'h7, 8'h80, 8'h00, 1'b1, 8'h01, 4'b0001, 4'b1011, 1'b1},
    {4'h8, 8'h01, 8'h00, 1'b1, 8'h80, 4'b1001, 4'b1011, 1'b1},
    {4'h9, 8'h40, 8'h40, 1'b0, 8'h00, 4'b0011, 4'b1011, 1'b0},
    {4'h9, 8'h10, 8'h20, 1'b0, 8'hF0, 4'b1000, 4'b1011, 1'b0},
    {4'hA, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b0010, 4'b1010, 1'b1},
    {4'hB, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b1000, 4'b1010, 1'b1},
    {4'hC, 8'h01, 8'hC0, 1'b0, 8'h00, 4'b1110, 4'b1110, 1'b0},
    {4'hD, 8'h12, 8'h34, 1'b1, 8'h00, 4'b0000, 4'b0000, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0: return "R2";
      4'h1: return "R3";
      4'h2, 4'h3, 4'h4: return "R4";
      4'h5, 4'h6, 4'h7, 4'h8: return "R5";
      4'h9: return "R6";
      4'hA, 4'hB: return "R7";
      4'hC: return "R8";
      default: return "R11";
    endcase
  endfunction

  // independent behavioural model: {res, N, V, Z, C, mask, wr}
  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] r,
                                         input logic [7:0] m, input logic c);
    int s;
    logic [7:0] res = 8'h00;
    logic n = 0, v = 0, z = 0, cy = 0, wr = 0;
    logic [3:0] mk = 4'b0000;
    case (op)
      4'h0: begin s = int'(r) + int'(m) + (c ? 1 : 0); res = s[7:0]; cy = s > 255;
                  v = (r[7] == m[7]) && (res[7] != r[7]); mk = 4'b1111; wr = 1; end
      4'h1: begin s = int'(r) - int'(m) - (c ? 0 : 1); res = s[7:0]; cy = s >= 0;
                  v = (r[7] != m[7]) && (res[7] != r[7]); mk = 4'b1111; wr = 1; end
      4'h2: begin res = r & m; mk = 4'b1010; wr = 1; end
      4'h3: begin res = r | m; mk = 4'b1010; wr = 1; end
      4'h4: begin res = r ^ m; mk = 4'b1010; wr = 1; end
      4'h5: begin res = r << 1; cy = r[7]; mk = 4'b1011; wr = 1; end
      4'h6: begin res = r >> 1; cy = r[0]; mk = 4'b1011; wr = 1; end
      4'h7: begin res = {r[6:0], c}; cy = r[7]; mk = 4'b1011; wr = 1; end
      4'h8: begin res = {c, r[7:1]}; cy = r[0]; mk = 4'b1011; wr = 1; end
      4'h9: begin res = r - m; cy = (r >= m); mk = 4'b1011; end
      4'hA: begin res = r + 8'd1; mk = 4'b1010; wr = 1; end
      4'hB: begin res = r - 8'd1; mk = 4'b1010; wr = 1; end
      4'hC: begin res = r & m; mk = 4'b1110; end
      default: ;
    endcase
    if (op == 4'hC) begin n = m[7]; v = m[6]; end
    else n = res[7] & mk[3];
    z = (res == 8'h00) & mk[1];
    return {res, n, v, z, cy, mk, wr};
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [16:0] observed();
    return {result, flag_n, flag_v, flag_z, flag_c, upd_mask, wr_result};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] r,
                       input logic [7:0] m, input logic c);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_r = r; opnd_m = m; carry_in = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [16:0] hold_val;
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; opnd_r = '0; opnd_m = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {observed()}, 17'h0);
    check_bit("R1 reset out_valid", out_valid, 1'b0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][37:34], TBL[i][33:26], TBL[i][25:18], TBL[i][17]);
      check(tag_of(TBL[i][37:34]), observed(), TBL[i][16:0]);
      check_bit("R1 out_valid", out_valid, 1'b1);
    end

    // R9: zero from signed overflow on add
    apply(4'h0, 8'h80, 8'h80, 1'b0);
    check("R9 add zero", observed(), {8'h00, 4'b0111, 4'b1111, 1'b1});

    // R4: logic leaves V and C at zero even with carry_in set
    apply(4'h4, 8'hFF, 8'h7F, 1'b1);
    check("R4 xor carry_in ignored", observed(), {8'h80, 4'b1000, 4'b1010, 1'b1});

    // R10: idle cycles hold outputs
    hold_val = observed();
    @(negedge clk);
    op_sel = 4'h0; opnd_r = 8'h33; opnd_m = 8'h44; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold", observed(), hold_val);
    check_bit("R10 out_valid low", out_valid, 1'b0);

    // random against the model (R2..R9, R11)
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      logic [7:0] r, m;
      logic c;
      op = 4'($urandom_range(0, 15));
      r  = 8'($urandom);
      m  = 8'($urandom);
      c  = 1'($urandom);
      apply(op, r, m, c);
      check(tag_of(op), observed(), model(op, r, m, c));
    end

    // R1: reset clears after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after use", observed(), 17'h0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule